// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block turns one channel's three-level PWM command into the two gate enables of a synchronous half-bridge: an upper (high-side) enable and a lower (low-side) enable. Dead time is not a fixed count. After a gate is released, the sequencer waits for a feedback flag that reports that gate below its threshold (about 1 V). Only then does it count a short, fixed turn-on delay before it enables the opposite gate. A gate that never reports low therefore leaves both gates off indefinitely. No timeout forces a turn-on.

Each turn-off edge is delayed by its own count. The upper gate's turn-off delay is lengthened by an extension value that a current-balance block supplies. A mid-level (tri-state) command releases whichever gate is on at once. If the command stays tri-state past a holdoff window, the channel enters a shutdown state. When the command leaves shutdown, the gate it names turns on after a separate turn-on delay of its own. All delays are parameters in clock cycles. The asynchronous reset is released through an internal two-flop synchronizer, so the sequencer leaves reset two clock edges after `rst_n` rises.

Top module: `gate_sequencer`

## Requirements
- R1: After reset both enables are 0 and the sequencer is in shutdown, so its first turn-on uses the T_TS turn-on delay (see R9).
- R2: `ug_en` and `lg_en` are never 1 in the same cycle.
- R3: With the lower gate on, a command of HIGH (`pwm_cmd`=2'b01) sampled at an edge makes `lg_en` fall TOFF_LG cycles after that edge. If the command returns to LOW (2'b00) before then, `lg_en` stays 1 with no gap.
- R4: While waiting to turn the upper gate on, `ug_en` rises TON_UG cycles after the first edge that samples `lg_low_fb`=1. While the flag stays 0, both enables stay 0 with no timeout.
- R5: With the upper gate on, a LOW command sampled at an edge makes `ug_en` fall TOFF_UG + `toff_ext` cycles after that edge, using the `toff_ext` value sampled at that same edge.
- R6: While waiting to turn the lower gate on, `lg_en` rises TON_LG cycles after the first edge that samples `ug_low_fb`=1.
- R7: If the awaited feedback flag drops to 0 during the turn-on delay, the delay is abandoned. The full delay restarts at the next edge that samples the flag at 1.
- R8: A tri-state command (`pwm_cmd[1]`=1) sampled at an edge turns off any enable that is on, right after that edge, including an enable that is inside its turn-off delay.
- R9: If the tri-state command is sampled at TRI_HOLD+1 consecutive edges, the sequencer enters shutdown. The next turn-on then takes T_TS cycles from the flag edge instead of the normal delay.
- R10: If the command leaves tri-state after at most TRI_HOLD tri-state samples, turn-on uses the normal TON_UG or TON_LG delay.
- R11: The code 2'b11 is treated exactly as tri-state, both for the immediate turn-off and for the shutdown holdoff.
- R12: A HIGH command sampled while waiting for the lower gate's turn-on redirects the sequencer to wait for the upper gate's turn-on, and the lower gate is never enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwm_cmd | input | 2 | Command: 2'b00 LOW, 2'b01 HIGH, 2'b1x tri-state |
| ug_low_fb | input | 1 | Upper gate is below its threshold |
| lg_low_fb | input | 1 | Lower gate is below its threshold |
| toff_ext | input | EXT_W | Extra cycles added to the upper gate's turn-off delay |
| ug_en | output | 1 | Upper gate enable |
| lg_en | output | 1 | Lower gate enable |

## Verification
The bench sweeps the turn-off extension over its full range and measures each of the four delays of a complete switching cycle. A design that sampled the extension late, or that miscounted a delay by one, would show up as an edge that is one or more cycles off. The tri-state dwell time is swept across the holdoff boundary, which separates the normal turn-on delay from the turn-on delay used after shutdown. An off-by-one holdoff would pick the wrong delay at that boundary. Further stimulus aborts a turn-off half-way, withdraws feedback during a turn-on delay, withholds feedback entirely, and reverses the command while the sequencer waits for a turn-on. A design that timed out, glitched the lower gate, or turned on without feedback would fail these checks.

// File: rtl/gate_seq_pkg.sv
package gate_seq_pkg;

  typedef enum logic [1:0] {
    CMD_LOW  = 2'd0,
    CMD_HIGH = 2'd1,
    CMD_TRI  = 2'd2
  } cmd_e;

  typedef enum logic [3:0] {
    ST_SHUT       = 4'd0,
    ST_TRI_HOLD   = 4'd1,
    ST_LG_ON      = 4'd2,
    ST_LG_OFF_DLY = 4'd3,
    ST_UG_ARM     = 4'd4,
    ST_UG_DLY     = 4'd5,
    ST_UG_ON      = 4'd6,
    ST_UG_OFF_DLY = 4'd7,
    ST_LG_ARM     = 4'd8,
    ST_LG_DLY     = 4'd9
  } seq_state_e;

endpackage

// File: rtl/gs_cmd_decode.sv
module gs_cmd_decode
  import gate_seq_pkg::*;
(
  input  logic [1:0] raw_cmd,
  output cmd_e       cmd
);

  always_comb begin
    unique case (raw_cmd)
      2'b00:   cmd = CMD_LOW;
      2'b01:   cmd = CMD_HIGH;
      default: cmd = CMD_TRI;
    endcase
  end

endmodule

// File: rtl/gs_delay_timer.sv
module gs_delay_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  // next-state
  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - CW'(1));
  end

  // register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/gs_seq_fsm.sv
module gs_seq_fsm
  import gate_seq_pkg::*;
#(
  parameter int TOFF_LG  = 5,
  parameter int TOFF_UG  = 5,
  parameter int TON_UG   = 3,
  parameter int TON_LG   = 3,
  parameter int TRI_HOLD = 3,
  parameter int TON_TS   = 3,
  parameter int EXT_W    = 3,
  parameter int CW       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cmd_e             cmd,
  input  logic             ug_low_fb,
  input  logic             lg_low_fb,
  input  logic [EXT_W-1:0] toff_ext,
  input  logic             tmr_expired,
  output logic             tmr_load,
  output logic [CW-1:0]    tmr_val,
  output logic             ug_en,
  output logic             lg_en
);

  localparam logic [CW-1:0] LD_TOFF_LG = CW'(TOFF_LG - 1);
  localparam logic [CW-1:0] LD_TOFF_UG = CW'(TOFF_UG - 1);
  localparam logic [CW-1:0] LD_TRI     = CW'(TRI_HOLD - 1);
  localparam logic [CW-1:0] DLY_UG     = CW'(TON_UG);
  localparam logic [CW-1:0] DLY_LG     = CW'(TON_LG);
  localparam logic [CW-1:0] DLY_TS     = CW'(TON_TS);

  seq_state_e    state_q, state_d;
  logic [CW-1:0] on_dly_q, on_dly_d;
  logic          on_dly_we;

  // next-state
  always_comb begin
    state_d   = state_q;
    on_dly_d  = on_dly_q;
    on_dly_we = 1'b0;
    tmr_load  = 1'b0;
    tmr_val   = '0;

    if (cmd == CMD_TRI) begin
      if (state_q == ST_TRI_HOLD) begin
        if (tmr_expired) state_d = ST_SHUT;
      end else if (state_q != ST_SHUT) begin
        state_d  = ST_TRI_HOLD;
        tmr_load = 1'b1;
        tmr_val  = LD_TRI;
      end
    end else begin
      unique case (state_q)
        ST_SHUT, ST_TRI_HOLD: begin
          on_dly_we = 1'b1;
          if (cmd == CMD_HIGH) begin
            state_d  = ST_UG_ARM;
            on_dly_d = (state_q == ST_SHUT) ? DLY_TS : DLY_UG;
          end else begin
            state_d  = ST_LG_ARM;
            on_dly_d = (state_q == ST_SHUT) ? DLY_TS : DLY_LG;
          end
        end
        ST_LG_ON: begin
          if (cmd == CMD_HIGH) begin
            state_d  = ST_LG_OFF_DLY;
            tmr_load = 1'b1;
            tmr_val  = LD_TOFF_LG;
          end
        end
        ST_LG_OFF_DLY: begin
          if (cmd == CMD_LOW) begin
            state_d = ST_LG_ON;
          end else if (tmr_expired) begin
            state_d   = ST_UG_ARM;
            on_dly_we = 1'b1;
            on_dly_d  = DLY_UG;
          end
        end
        ST_UG_ARM, ST_UG_DLY: begin
          if (cmd == CMD_LOW) begin
            state_d   = ST_LG_ARM;
            on_dly_we = 1'b1;
            on_dly_d  = DLY_LG;
          end else if (!lg_low_fb) begin
            state_d = ST_UG_ARM;
          end else if (state_q == ST_UG_ARM) begin
            state_d  = ST_UG_DLY;
            tmr_load = 1'b1;
            tmr_val  = on_dly_q - CW'(1);
          end else if (tmr_expired) begin
            state_d = ST_UG_ON;
          end
        end
        ST_UG_ON: begin
          if (cmd == CMD_LOW) begin
            state_d  = ST_UG_OFF_DLY;
            tmr_load = 1'b1;
            tmr_val  = LD_TOFF_UG + CW'(toff_ext);
          end
        end
        ST_UG_OFF_DLY: begin
          if (cmd == CMD_HIGH) begin
            state_d = ST_UG_ON;
          end else if (tmr_expired) begin
            state_d   = ST_LG_ARM;
            on_dly_we = 1'b1;
            on_dly_d  = DLY_LG;
          end
        end
        ST_LG_ARM, ST_LG_DLY: begin
          if (cmd == CMD_HIGH) begin
            state_d   = ST_UG_ARM;
            on_dly_we = 1'b1;
            on_dly_d  = DLY_UG;
          end else if (!ug_low_fb) begin
            state_d = ST_LG_ARM;
          end else if (state_q == ST_LG_ARM) begin
            state_d  = ST_LG_DLY;
            tmr_load = 1'b1;
            tmr_val  = on_dly_q - CW'(1);
          end else if (tmr_expired) begin
            state_d = ST_LG_ON;
          end
        end
        default: state_d = ST_SHUT;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SHUT;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_dly_q <= DLY_TS;
    end else if (on_dly_we) begin
      on_dly_q <= on_dly_d;
    end
  end

  assign ug_en = (state_q == ST_UG_ON) || (state_q == ST_UG_OFF_DLY);
  assign lg_en = (state_q == ST_LG_ON) || (state_q == ST_LG_OFF_DLY);

endmodule

// File: rtl/gs_rst_sync.sv
module gs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/gate_sequencer.sv
module gate_sequencer
  import gate_seq_pkg::*;
#(
  parameter int TOFF_LG  = 5,
  parameter int TOFF_UG  = 5,
  parameter int TON_UG   = 3,
  parameter int TON_LG   = 3,
  parameter int TRI_HOLD = 3,
  parameter int TON_TS   = 3,
  parameter int EXT_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       pwm_cmd,
  input  logic             ug_low_fb,
  input  logic             lg_low_fb,
  input  logic [EXT_W-1:0] toff_ext,
  output logic             ug_en,
  output logic             lg_en
);

  localparam int EXT_MAX = (1 << EXT_W) - 1;
  localparam int M_OFF   = (TOFF_LG > TOFF_UG + EXT_MAX) ? TOFF_LG : TOFF_UG + EXT_MAX;
  localparam int M_ON    = (TON_UG > TON_LG) ? TON_UG : TON_LG;
  localparam int M_MISC  = (TRI_HOLD > TON_TS) ? TRI_HOLD : TON_TS;
  localparam int M_A     = (M_OFF > M_ON) ? M_OFF : M_ON;
  localparam int DMAX    = (M_A > M_MISC) ? M_A : M_MISC;
  localparam int CW      = $clog2(DMAX + 1);

  logic          core_rst_n;
  cmd_e          cmd;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_expired;

  gs_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (core_rst_n)
  );

  gs_cmd_decode i_decode (
    .raw_cmd (pwm_cmd),
    .cmd     (cmd)
  );

  gs_delay_timer #(.CW(CW)) i_timer (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  gs_seq_fsm #(
    .TOFF_LG  (TOFF_LG),
    .TOFF_UG  (TOFF_UG),
    .TON_UG   (TON_UG),
    .TON_LG   (TON_LG),
    .TRI_HOLD (TRI_HOLD),
    .TON_TS   (TON_TS),
    .EXT_W    (EXT_W),
    .CW       (CW)
  ) i_fsm (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .cmd         (cmd),
    .ug_low_fb   (ug_low_fb),
    .lg_low_fb   (lg_low_fb),
    .toff_ext    (toff_ext),
    .tmr_expired (tmr_expired),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .ug_en       (ug_en),
    .lg_en       (lg_en)
  );

endmodule

// File: rtl/gate_sequencer_checker.sv
module gate_sequencer_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] pwm_cmd,
  input logic       ug_low_fb,
  input logic       lg_low_fb,
  input logic       ug_en,
  input logic       lg_en
);

  assert_no_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(ug_en && lg_en));

  assert_ug_needs_fb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ug_en) |-> $past(lg_low_fb));

  assert_lg_needs_fb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lg_en) |-> $past(ug_low_fb));

  assert_tri_cuts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_cmd[1] && (ug_en || lg_en)) |=> (!ug_en && !lg_en));

  assert_ug_fall_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ug_en) |-> ($past(pwm_cmd) != 2'b01));

  assert_lg_fall_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lg_en) |-> ($past(pwm_cmd) != 2'b00));

endmodule

bind gate_sequencer gate_sequencer_checker i_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .pwm_cmd   (pwm_cmd),
  .ug_low_fb (ug_low_fb),
  .lg_low_fb (lg_low_fb),
  .ug_en     (ug_en),
  .lg_en     (lg_en)
);

// File: tb/test_gate_sequencer.sv
`timescale 1ns/1ps
module test_gate_sequencer;

  localparam int P_TOFF_LG = 4;
  localparam int P_TOFF_UG = 3;
  localparam int P_TON_UG  = 2;
  localparam int P_TON_LG  = 1;
  localparam int P_TRI     = 3;
  localparam int P_TON_TS  = 5;
  localparam int P_EXT_W   = 2;

  localparam logic [1:0] C_LOW  = 2'b00;
  localparam logic [1:0] C_HIGH = 2'b01;
  localparam logic [1:0] C_TRI  = 2'b10;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [1:0]         pwm_cmd = C_TRI;
  logic               ug_low_fb = 1'b0;
  logic               lg_low_fb = 1'b0;
  logic [P_EXT_W-1:0] toff_ext = '0;
  logic               ug_en;
  logic               lg_en;

  int  checks = 0;
  int  errors = 0;
  bit  overlap = 1'b0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  gate_sequencer #(
    .TOFF_LG (P_TOFF_LG), .TOFF_UG (P_TOFF_UG), .TON_UG (P_TON_UG),
    .TON_LG (P_TON_LG), .TRI_HOLD (P_TRI), .TON_TS (P_TON_TS), .EXT_W (P_EXT_W)
  ) i_gate_sequencer (
    .clk (clk), .rst_n (rst_n), .pwm_cmd (pwm_cmd), .ug_low_fb (ug_low_fb),
    .lg_low_fb (lg_low_fb), .toff_ext (toff_ext), .ug_en (ug_en), .lg_en (lg_en)
  );

  task automatic step();
    @(posedge clk);
    #1;
    if (ug_en && lg_en) overlap = 1'b1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic count_until(input bit on_ug, input bit level, output int n);
    n = 0;
    for (int i = 0; i < 64; i++) begin
      step();
      n++;
      if ((on_ug ? ug_en : lg_en) == level) return;
    end
    n = 999;
  endtask

  task automatic go_lower_on();
    int n;
    pwm_cmd = C_LOW; ug_low_fb = 1'b1; lg_low_fb = 1'b0;
    if (!lg_en) count_until(1'b0, 1'b1, n);
  endtask

  task automatic go_upper_on();
    int n;
    pwm_cmd = C_HIGH; lg_low_fb = 1'b1; ug_low_fb = 1'b0;
    if (!ug_en) count_until(1'b1, 1'b1, n);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    int m;
    bit seen;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();
    check("R1 ug_en after reset", ug_en, 0);
    check("R1 lg_en after reset", lg_en, 0);

    // R1: first turn-on from reset uses the shutdown delay
    pwm_cmd = C_LOW; ug_low_fb = 1'b1;
    count_until(1'b0, 1'b1, n);
    check("R1 first turn-on latency", n, P_TON_TS + 2);

    // sweep of the extension over a full switching cycle
    for (int e = 0; e < (1 << P_EXT_W); e++) begin
      go_lower_on();
      pwm_cmd = C_HIGH;
      count_until(1'b0, 1'b0, n);
      check("R3 lower turn-off delay", n, P_TOFF_LG + 1);
      if (e == 0) begin
        repeat (6) step();
        check("R4 no turn-on without feedback", ug_en, 0);
      end
      lg_low_fb = 1'b1;
      count_until(1'b1, 1'b1, n);
      check("R4 upper turn-on delay", n, P_TON_UG + 1);
      ug_low_fb = 1'b0;
      pwm_cmd = C_LOW;
      toff_ext = P_EXT_W'(e);
      step();
      toff_ext = P_EXT_W'(3 - e);
      count_until(1'b1, 1'b0, m);
      check("R5 upper turn-off with extension", m + 1, P_TOFF_UG + e + 1);
      ug_low_fb = 1'b1;
      count_until(1'b0, 1'b1, n);
      check("R6 lower turn-on delay", n, P_TON_LG + 1);
    end

    // R3: aborted turn-off keeps lower gate on
    go_lower_on();
    pwm_cmd = C_HIGH;
    seen = 1'b0;
    repeat (2) begin step(); if (!lg_en) seen = 1'b1; end
    pwm_cmd = C_LOW;
    repeat (8) begin step(); if (!lg_en) seen = 1'b1; end
    check("R3 aborted turn-off leaves no gap", seen, 0);

    // R7: feedback withdrawn during turn-on delay
    go_lower_on();
    pwm_cmd = C_HIGH;
    count_until(1'b0, 1'b0, n);
    lg_low_fb = 1'b1;
    step();
    lg_low_fb = 1'b0;
    seen = 1'b0;
    repeat (P_TON_UG + 3) begin step(); if (ug_en) seen = 1'b1; end
    check("R7 no turn-on after withdrawn feedback", seen, 0);
    lg_low_fb = 1'b1;
    count_until(1'b1, 1'b1, n);
    check("R7 full delay restarts", n, P_TON_UG + 1);

    // R8: tri-state cuts any conducting gate
    go_upper_on();
    pwm_cmd = C_TRI;
    step();
    check("R8 tri cuts upper gate", ug_en, 0);
    go_lower_on();
    pwm_cmd = C_TRI;
    step();
    check("R8 tri cuts lower gate", lg_en, 0);
    go_lower_on();
    pwm_cmd = C_HIGH;
    step();
    pwm_cmd = C_TRI;
    step();
    check("R8 tri cuts gate inside turn-off delay", lg_en, 0);

    // R9 / R10: sweep tri dwell across the holdoff boundary
    for (int len = 1; len <= P_TRI + 2; len++) begin
      go_lower_on();
      pwm_cmd = C_TRI;
      repeat (len) step();
      lg_low_fb = 1'b1;
      pwm_cmd = C_HIGH;
      count_until(1'b1, 1'b1, n);
      if (len <= P_TRI)
        check("R10 short tri keeps normal delay", n, P_TON_UG + 2);
      else
        check("R9 long tri uses shutdown delay", n, P_TON_TS + 2);
    end

    // R11: code 2'b11 behaves as tri-state
    go_upper_on();
    pwm_cmd = 2'b11;
    step();
    check("R11 code 3 cuts upper gate", ug_en, 0);
    repeat (P_TRI) step();
    pwm_cmd = C_HIGH; lg_low_fb = 1'b1;
    count_until(1'b1, 1'b1, n);
    check("R11 code 3 reaches shutdown", n, P_TON_TS + 2);

    // R12: reversal while waiting for lower turn-on
    go_upper_on();
    ug_low_fb = 1'b0;
    pwm_cmd = C_LOW;
    count_until(1'b1, 1'b0, n);
    repeat (3) step();
    check("R12 lower waits for feedback", lg_en, 0);
    pwm_cmd = C_HIGH; lg_low_fb = 1'b1;
    seen = 1'b0;
    for (int i = 0; i < 20; i++) begin
      step();
      if (lg_en) seen = 1'b1;
      if (ug_en) begin n = i + 1; break; end
    end
    check("R12 redirected upper turn-on", n, P_TON_UG + 2);
    check("R12 lower never enabled", seen, 0);

    check("R2 enables never overlap", overlap, 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule